// File: doc/BRIEF.md
# Lane Configuration Source Selector

This block is the control plane of a four-lane signal-conditioning device. For each lane it decides whether the equalization, de-emphasis, line-rate, input-termination and electrical-idle settings come from external strap pins or from an internal register bank. It then drives the resulting per-lane setting words to the analog lanes.

A mode input selects the source. With the mode input low the block is in pin mode. Settings are then grouped by side: lanes 0 and 1 form side A, and lanes 2 and 3 form side B. With the mode input high the block is in register mode and the settings are held per lane in registers. The four equalization/de-emphasis strap pins then stop acting as settings and instead supply a four-bit bus address for the external serial management engine. That engine is represented here by a plain write port and a combinational read port.

A three-state machine tracks the source, with these states:
- `ST_PIN`: pin control.
- `ST_REG`: register control.
- `ST_REG_PRS`: register control while the presence input is high.

Its transitions are:
- `ST_PIN` to `ST_REG` on mode high.
- `ST_REG` to `ST_REG_PRS` on presence high.
- `ST_REG_PRS` to `ST_REG` on presence low.
- Any state to `ST_PIN` on mode low.

The register bank is cleared at reset and on every clock edge that sees the mode input low. Presence never clears it.

Top module: `cfgsel_top`

## Requirements
- R1: A clock edge that samples `mode_i` high puts the block in register mode (`reg_mode_o`=1). From that edge on, rate, equalization and de-emphasis come from the register bank. An edge that samples `mode_i` low returns the block to pin mode on that same edge.
- R2: In pin mode, `strap_i[0]` and `strap_i[1]` select equalization for side A (lanes 0,1) and side B (lanes 2,3). A value of 1 gives code 5'b01_011 and 0 gives bypass 5'b00_000. `strap_i[2]` and `strap_i[3]` select de-emphasis for sides A and B, where 1 gives 2'b01 and 0 gives 2'b00. Lane k's equalization sits at `eq_o[5k+4:5k]` and its de-emphasis at `dem_o[2k+1:2k]`.
- R3: In register mode, writes to word 0..3 set the equalization of lanes 0..3 from data[4:0], laid out as {gain[1:0], boost[2:0]}. A write to word 4 sets all four de-emphasis fields, with lane k at data[2k+1:2k]. Each write shows at the outputs right after the edge that samples it.
- R4: `bus_addr_o` equals `strap_i` in register mode and is 0 in pin mode. In register mode the strap pins have no effect on any setting.
- R5: A written equalization code whose boost field is above 3'b101 is stored as bypass 5'b00_000. The 24 codes with boost 0..5 are stored as written.
- R6: Termination and idle keep following their pins in register mode. Each switches to its register only when both of these hold: its override bit in word 8 is set (bit0 for termination, bit1 for idle), and its setting word has been written (word 6 for termination, word 7 for idle). From then on, pin changes are ignored.
- R7: Reset and every edge with `mode_i` low return all registers to their defaults: equalization bypass, de-emphasis 0, rate auto, termination auto, idle pass-through, overrides and written flags clear. Writes in pin mode are ignored.
- R8: A presence pulse while in register mode leaves all register contents and all outputs unchanged.
- R9: Each side's 2-bit idle pin code is 2'b10 for force idle, 2'b01 for pass detected idle (float), 2'b00 for squelch disabled, and 2'b11 read as float. The code is driven per lane on `idle_o[2k+1:2k]`. Side A is pins [1:0] and side B is pins [3:2]. Word 7 holds side A at data[1:0] and side B at data[3:2].
- R10: With `rxdet_en_i` low, termination is auto (2'b00). With it high, `rxdet_side_i[s]`=1 forces termination on (2'b01) and 0 forces it off (2'b10). Word 6 sets lane k at data[2k+1:2k].
- R11: The rate code is 2'b00 for 2.5 Gb/s, 2'b01 for 5 Gb/s, 2'b10 for auto, and 2'b11 is read as auto. It comes from `rate_pin_i` in pin mode and from word 5 data[1:0] in register mode.
- R12: `rd_data_o` returns the effective value at `rd_addr_i`:
  - words 0..3: lane equalization;
  - word 4: de-emphasis;
  - word 5: rate;
  - word 6: termination;
  - word 7: idle per side;
  - word 8: override bits;
  - any other word: 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| mode_i | input | 1 | 0 = pin mode, 1 = register mode |
| present_i | input | 1 | Presence indication |
| strap_i | input | 4 | EQ A, EQ B, DEM A, DEM B straps; bus address in register mode |
| rate_pin_i | input | 2 | Rate pin code |
| rxdet_en_i | input | 1 | Enables manual termination pins |
| rxdet_side_i | input | 2 | Manual termination per side (bit0 A, bit1 B) |
| idle_pin_i | input | 4 | Three-level idle code per side |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write word address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 4 | Read word address |
| rd_data_o | output | 8 | Effective value at read address |
| eq_o | output | 20 | Per-lane equalization codes |
| dem_o | output | 8 | Per-lane de-emphasis codes |
| rate_o | output | 2 | Effective rate code |
| term_o | output | 8 | Per-lane termination codes |
| idle_o | output | 8 | Per-lane idle codes |
| bus_addr_o | output | 4 | Serial bus address |
| reg_mode_o | output | 1 | High while in register mode |

## Verification
A wrong mode state shows on the edge after the mode input changes. `bus_addr_o`, `rate_o` and the per-lane equalization words then keep or take pin-derived values when they should not. A stuck or missed bank clear only becomes visible on re-entry into register mode, when defaults fail to appear on that first edge. A wrong override qualification shows as soon as a termination or idle pin toggles after the override is armed. A bad clamp appears both on the equalization output and on the read port right after the write edge.

// File: rtl/cfgsel_pkg.sv
package cfgsel_pkg;

    localparam int LANES     = 4;
    localparam int SIDES     = 2;
    localparam int LPS       = LANES / SIDES;
    localparam int GST_W     = 2;
    localparam int BST_W     = 3;
    localparam int EQ_W      = GST_W + BST_W;
    localparam int DEM_W     = 2;
    localparam int RATE_W    = 2;
    localparam int TERM_W    = 2;
    localparam int IDLE_W    = 2;
    localparam int STRAP_W   = 2 * SIDES;
    localparam int REG_AW    = 4;
    localparam int REG_DW    = 8;
    localparam int BST_MAX   = 5;
    localparam int OVR_W     = 2;
    localparam int OVR_TERM  = 0;
    localparam int OVR_IDLE  = 1;

    localparam logic [EQ_W-1:0]   EQ_BYPASS  = '0;
    localparam logic [EQ_W-1:0]   EQ_PIN_HI  = 5'b01_011;
    localparam logic [DEM_W-1:0]  DEM_NONE   = 2'b00;
    localparam logic [DEM_W-1:0]  DEM_PIN_HI = 2'b01;
    localparam logic [RATE_W-1:0] RATE_AUTO  = 2'b10;
    localparam logic [TERM_W-1:0] TERM_AUTO  = 2'b00;
    localparam logic [TERM_W-1:0] TERM_ON    = 2'b01;
    localparam logic [TERM_W-1:0] TERM_OFF   = 2'b10;
    localparam logic [IDLE_W-1:0] IDLE_PASS  = 2'b01;

    localparam logic [REG_AW-1:0] A_EQ_BASE = 4'h0;
    localparam logic [REG_AW-1:0] A_DEM     = 4'h4;
    localparam logic [REG_AW-1:0] A_RATE    = 4'h5;
    localparam logic [REG_AW-1:0] A_TERM    = 4'h6;
    localparam logic [REG_AW-1:0] A_IDLE    = 4'h7;
    localparam logic [REG_AW-1:0] A_OVR     = 4'h8;

    typedef enum logic [1:0] {
        ST_PIN     = 2'd0,
        ST_REG     = 2'd1,
        ST_REG_PRS = 2'd2
    } src_state_e;

    // Out-of-table boost values fall back to bypass.
    function automatic logic [EQ_W-1:0] eq_clamp(input logic [EQ_W-1:0] code);
        if (int'(code[BST_W-1:0]) > BST_MAX) return EQ_BYPASS;
        return code;
    endfunction

    // Reserved rate code maps to auto.
    function automatic logic [RATE_W-1:0] rate_norm(input logic [RATE_W-1:0] code);
        return (code == 2'b11) ? RATE_AUTO : code;
    endfunction

    // Reserved idle code maps to pass-through.
    function automatic logic [IDLE_W-1:0] idle_norm(input logic [IDLE_W-1:0] code);
        return (code == 2'b11) ? IDLE_PASS : code;
    endfunction

endpackage

// File: rtl/cfgsel_mode_fsm.sv
module cfgsel_mode_fsm
    import cfgsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_i,
    input  logic present_i,
    output logic reg_mode_o,
    output logic hold_o
);

    src_state_e state_q;
    src_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PIN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PIN: begin
                if (mode_i) state_d = ST_REG;
            end
            ST_REG: begin
                if (!mode_i)        state_d = ST_PIN;
                else if (present_i) state_d = ST_REG_PRS;
            end
            ST_REG_PRS: begin
                if (!mode_i)         state_d = ST_PIN;
                else if (!present_i) state_d = ST_REG;
            end
            default: state_d = ST_PIN;
        endcase
    end

    always_comb begin
        reg_mode_o = 1'b0;
        hold_o     = 1'b0;
        unique case (state_q)
            ST_PIN:     ;
            ST_REG:     reg_mode_o = 1'b1;
            ST_REG_PRS: begin
                reg_mode_o = 1'b1;
                hold_o     = 1'b1;
            end
            default:    ;
        endcase
    end

    // R1: the source follows the mode input one edge later.
    a_r1_enter_reg: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> reg_mode_o);
    a_r1_leave_reg: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> !reg_mode_o);
    // R8: presence state only exists inside register mode.
    a_r8_hold_in_reg: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |-> reg_mode_o);

endmodule

// File: rtl/cfgsel_regbank.sv
module cfgsel_regbank
    import cfgsel_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear_i,
    input  logic                      hold_i,
    input  logic                      wr_en_i,
    input  logic [REG_AW-1:0]         wr_addr_i,
    input  logic [REG_DW-1:0]         wr_data_i,
    output logic [LANES*EQ_W-1:0]     eq_o,
    output logic [LANES*DEM_W-1:0]    dem_o,
    output logic [RATE_W-1:0]         rate_o,
    output logic [LANES*TERM_W-1:0]   term_o,
    output logic [SIDES*IDLE_W-1:0]   idle_o,
    output logic [OVR_W-1:0]          ovr_o,
    output logic                      term_wr_o,
    output logic                      idle_wr_o
);

    localparam logic [SIDES*IDLE_W-1:0] IDLE_DEF = {SIDES{IDLE_PASS}};
    localparam logic [LANES*TERM_W-1:0] TERM_DEF = {LANES{TERM_AUTO}};

    logic hit_dem, hit_rate, hit_term, hit_idle, hit_ovr;

    assign hit_dem  = wr_en_i && (wr_addr_i == A_DEM);
    assign hit_rate = wr_en_i && (wr_addr_i == A_RATE);
    assign hit_term = wr_en_i && (wr_addr_i == A_TERM);
    assign hit_idle = wr_en_i && (wr_addr_i == A_IDLE);
    assign hit_ovr  = wr_en_i && (wr_addr_i == A_OVR);

    for (genvar i = 0; i < LANES; i++) begin : g_eq
        logic [EQ_W-1:0] eq_q;
        logic            hit;
        assign hit = wr_en_i && (wr_addr_i == A_EQ_BASE + REG_AW'(i));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       eq_q <= EQ_BYPASS;
            else if (clear_i) eq_q <= EQ_BYPASS;
            else if (hit)     eq_q <= eq_clamp(wr_data_i[EQ_W-1:0]);
        end
        assign eq_o[i*EQ_W +: EQ_W] = eq_q;

        // R5: a stored boost field never leaves the valid table.
        a_r5_eq_in_table: assert property (@(posedge clk) disable iff (!rst_n)
            int'(eq_o[i*EQ_W +: BST_W]) <= BST_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clear_i) begin
            dem_o     <= {LANES{DEM_NONE}};
            rate_o    <= RATE_AUTO;
            term_o    <= TERM_DEF;
            idle_o    <= IDLE_DEF;
            ovr_o     <= '0;
            term_wr_o <= 1'b0;
            idle_wr_o <= 1'b0;
        end else begin
            if (hit_dem)  dem_o  <= wr_data_i[LANES*DEM_W-1:0];
            if (hit_rate) rate_o <= rate_norm(wr_data_i[RATE_W-1:0]);
            if (hit_term) begin
                term_o    <= wr_data_i[LANES*TERM_W-1:0];
                term_wr_o <= 1'b1;
            end
            if (hit_idle) begin
                idle_o    <= wr_data_i[SIDES*IDLE_W-1:0];
                idle_wr_o <= 1'b1;
            end
            if (hit_ovr)  ovr_o  <= wr_data_i[OVR_W-1:0];
        end
    end

    // R7: an edge with the clear request leaves only defaults behind.
    a_r7_clear_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (eq_o == '0 && dem_o == '0 && rate_o == RATE_AUTO &&
                     ovr_o == '0 && !term_wr_o && !idle_wr_o));
    // R8: with no write and no clear, and in particular across presence, nothing moves.
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !wr_en_i) |=> $stable({eq_o, dem_o, rate_o, term_o, idle_o, ovr_o}));
    a_r8_presence_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clear_i && !wr_en_i) |=> $stable({eq_o, dem_o, term_o, idle_o}));

endmodule

// File: rtl/cfgsel_lane_mux.sv
module cfgsel_lane_mux
    import cfgsel_pkg::*;
(
    input  logic                      reg_mode_i,
    input  logic [STRAP_W-1:0]        strap_i,
    input  logic [RATE_W-1:0]         rate_pin_i,
    input  logic                      rxdet_en_i,
    input  logic [SIDES-1:0]          rxdet_side_i,
    input  logic [SIDES*IDLE_W-1:0]   idle_pin_i,
    input  logic [LANES*EQ_W-1:0]     r_eq_i,
    input  logic [LANES*DEM_W-1:0]    r_dem_i,
    input  logic [RATE_W-1:0]         r_rate_i,
    input  logic [LANES*TERM_W-1:0]   r_term_i,
    input  logic [SIDES*IDLE_W-1:0]   r_idle_i,
    input  logic                      term_sel_i,
    input  logic                      idle_sel_i,
    output logic [LANES*EQ_W-1:0]     eq_o,
    output logic [LANES*DEM_W-1:0]    dem_o,
    output logic [RATE_W-1:0]         rate_o,
    output logic [LANES*TERM_W-1:0]   term_o,
    output logic [LANES*IDLE_W-1:0]   idle_o,
    output logic [STRAP_W-1:0]        bus_addr_o
);

    assign rate_o     = reg_mode_i ? r_rate_i : rate_norm(rate_pin_i);
    assign bus_addr_o = reg_mode_i ? strap_i : '0;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int SIDE = i / LPS;

        logic [EQ_W-1:0]   pin_eq;
        logic [DEM_W-1:0]  pin_dem;
        logic [TERM_W-1:0] pin_term;
        logic [IDLE_W-1:0] pin_idle;

        always_comb begin
            pin_eq   = strap_i[SIDE]         ? EQ_PIN_HI  : EQ_BYPASS;
            pin_dem  = strap_i[SIDES + SIDE] ? DEM_PIN_HI : DEM_NONE;
            if (!rxdet_en_i)              pin_term = TERM_AUTO;
            else if (rxdet_side_i[SIDE])  pin_term = TERM_ON;
            else                          pin_term = TERM_OFF;
            pin_idle = idle_norm(idle_pin_i[SIDE*IDLE_W +: IDLE_W]);
        end

        assign eq_o[i*EQ_W +: EQ_W]       = reg_mode_i ? r_eq_i[i*EQ_W +: EQ_W]   : pin_eq;
        assign dem_o[i*DEM_W +: DEM_W]    = reg_mode_i ? r_dem_i[i*DEM_W +: DEM_W] : pin_dem;
        assign term_o[i*TERM_W +: TERM_W] = (reg_mode_i && term_sel_i) ?
                                            r_term_i[i*TERM_W +: TERM_W] : pin_term;
        assign idle_o[i*IDLE_W +: IDLE_W] = (reg_mode_i && idle_sel_i) ?
                                            idle_norm(r_idle_i[SIDE*IDLE_W +: IDLE_W]) : pin_idle;
    end

endmodule

// File: rtl/cfgsel_top.sv
module cfgsel_top
    import cfgsel_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      mode_i,
    input  logic                      present_i,
    input  logic [STRAP_W-1:0]        strap_i,
    input  logic [RATE_W-1:0]         rate_pin_i,
    input  logic                      rxdet_en_i,
    input  logic [SIDES-1:0]          rxdet_side_i,
    input  logic [SIDES*IDLE_W-1:0]   idle_pin_i,
    input  logic                      wr_en_i,
    input  logic [REG_AW-1:0]         wr_addr_i,
    input  logic [REG_DW-1:0]         wr_data_i,
    input  logic [REG_AW-1:0]         rd_addr_i,
    output logic [REG_DW-1:0]         rd_data_o,
    output logic [LANES*EQ_W-1:0]     eq_o,
    output logic [LANES*DEM_W-1:0]    dem_o,
    output logic [RATE_W-1:0]         rate_o,
    output logic [LANES*TERM_W-1:0]   term_o,
    output logic [LANES*IDLE_W-1:0]   idle_o,
    output logic [STRAP_W-1:0]        bus_addr_o,
    output logic                      reg_mode_o
);

    logic                      hold;
    logic                      wr_ok;
    logic                      term_sel, idle_sel;
    logic [LANES*EQ_W-1:0]     r_eq;
    logic [LANES*DEM_W-1:0]    r_dem;
    logic [RATE_W-1:0]         r_rate;
    logic [LANES*TERM_W-1:0]   r_term;
    logic [SIDES*IDLE_W-1:0]   r_idle;
    logic [OVR_W-1:0]          r_ovr;
    logic                      term_wr, idle_wr;
    logic [SIDES*IDLE_W-1:0]   idle_side;

    cfgsel_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .present_i  (present_i),
        .reg_mode_o (reg_mode_o),
        .hold_o     (hold)
    );

    assign wr_ok = wr_en_i && mode_i && reg_mode_o;

    cfgsel_regbank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (!mode_i),
        .hold_i    (hold),
        .wr_en_i   (wr_ok),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .eq_o      (r_eq),
        .dem_o     (r_dem),
        .rate_o    (r_rate),
        .term_o    (r_term),
        .idle_o    (r_idle),
        .ovr_o     (r_ovr),
        .term_wr_o (term_wr),
        .idle_wr_o (idle_wr)
    );

    assign term_sel = r_ovr[OVR_TERM] && term_wr;
    assign idle_sel = r_ovr[OVR_IDLE] && idle_wr;

    cfgsel_lane_mux u_mux (
        .reg_mode_i   (reg_mode_o),
        .strap_i      (strap_i),
        .rate_pin_i   (rate_pin_i),
        .rxdet_en_i   (rxdet_en_i),
        .rxdet_side_i (rxdet_side_i),
        .idle_pin_i   (idle_pin_i),
        .r_eq_i       (r_eq),
        .r_dem_i      (r_dem),
        .r_rate_i     (r_rate),
        .r_term_i     (r_term),
        .r_idle_i     (r_idle),
        .term_sel_i   (term_sel),
        .idle_sel_i   (idle_sel),
        .eq_o         (eq_o),
        .dem_o        (dem_o),
        .rate_o       (rate_o),
        .term_o       (term_o),
        .idle_o       (idle_o),
        .bus_addr_o   (bus_addr_o)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        assign idle_side[s*IDLE_W +: IDLE_W] = idle_o[s*LPS*IDLE_W +: IDLE_W];
    end

    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < LANES; k++) begin
            if (rd_addr_i == A_EQ_BASE + REG_AW'(k))
                rd_data_o = REG_DW'(eq_o[k*EQ_W +: EQ_W]);
        end
        case (rd_addr_i)
            A_DEM:   rd_data_o = REG_DW'(dem_o);
            A_RATE:  rd_data_o = REG_DW'(rate_o);
            A_TERM:  rd_data_o = REG_DW'(term_o);
            A_IDLE:  rd_data_o = REG_DW'(idle_side);
            A_OVR:   rd_data_o = REG_DW'(r_ovr);
            default: ;
        endcase
    end

    // R4: no address leaks out of pin mode.
    a_r4_addr_zero_in_pin: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_mode_o |-> bus_addr_o == '0);
    // R6: once termination is taken over, pins cannot move it.
    a_r6_term_pins_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode_o && term_sel && $past(reg_mode_o && term_sel) && !$past(wr_ok))
        |-> $stable(term_o));
    // R3: register-mode equalization only moves after a write edge.
    a_r3_eq_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_mode_o && $past(reg_mode_o) && !$past(wr_ok)) |-> $stable(eq_o));

endmodule

// File: tb/cfgsel_top_bench.sv
module cfgsel_top_bench;

    typedef struct packed {
        logic [3:0]  addr;
        logic [1:0]  rate;
        logic [19:0] eq;
        logic [7:0]  dem;
        logic [7:0]  term;
        logic [7:0]  idle;
        logic [7:0]  rd;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0, present_i = 1'b0;
    logic [3:0]  strap_i = '0;
    logic [1:0]  rate_pin_i = '0;
    logic        rxdet_en_i = 1'b0;
    logic [1:0]  rxdet_side_i = '0;
    logic [3:0]  idle_pin_i = 4'b0101;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_addr_i = '0;
    logic [7:0]  wr_data_i = '0;
    logic [3:0]  rd_addr_i = '0;
    logic [7:0]  rd_data_o;
    logic [19:0] eq_o;
    logic [7:0]  dem_o, term_o, idle_o;
    logic [1:0]  rate_o;
    logic [3:0]  bus_addr_o;
    logic        reg_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    obs_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    cfgsel_top u_cfgsel_top (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .present_i(present_i),
        .strap_i(strap_i), .rate_pin_i(rate_pin_i), .rxdet_en_i(rxdet_en_i),
        .rxdet_side_i(rxdet_side_i), .idle_pin_i(idle_pin_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .eq_o(eq_o),
        .dem_o(dem_o), .rate_o(rate_o), .term_o(term_o), .idle_o(idle_o),
        .bus_addr_o(bus_addr_o), .reg_mode_o(reg_mode_o)
    );

    // Monitor: compares observed ports with queued expectations at each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                obs_t  e;
                obs_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = '{bus_addr_o, rate_o, eq_o, dem_o, term_o, idle_o, rd_data_o};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", t, a, e);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        tick();
        wr_en_i = 1'b0;
    endtask

    task automatic expect_obs(input string tag, input logic [3:0] a, input logic [1:0] r,
                              input logic [19:0] e, input logic [7:0] d, input logic [7:0] t,
                              input logic [7:0] i, input logic [7:0] rd);
        exp_q.push_back('{a, r, e, d, t, i, rd});
        tag_q.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        expect_obs("R7 reset defaults", 4'h0, 2'b00, 20'h0, 8'h00, 8'h00, 8'h55, 8'h00);

        strap_i = 4'b0101;
        expect_obs("R2 side A straps", 4'h0, 2'b00, 20'h0016B, 8'h05, 8'h00, 8'h55, 8'h0B);
        strap_i = 4'b1010;
        expect_obs("R2 side B straps", 4'h0, 2'b00, 20'h5AC00, 8'h50, 8'h00, 8'h55, 8'h00);

        wr(4'h0, 8'h12);
        expect_obs("R7 write ignored in pin mode", 4'h0, 2'b00, 20'h5AC00, 8'h50, 8'h00, 8'h55, 8'h00);

        rate_pin_i = 2'b11;
        expect_obs("R11 reserved rate pin", 4'h0, 2'b10, 20'h5AC00, 8'h50, 8'h00, 8'h55, 8'h00);
        rate_pin_i = 2'b01;
        rxdet_en_i = 1'b1; rxdet_side_i = 2'b01; idle_pin_i = 4'b0010;
        expect_obs("R10 R9 pin termination idle", 4'h0, 2'b01, 20'h5AC00, 8'h50, 8'hA5, 8'h0A, 8'h00);
        idle_pin_i = 4'b0011;
        expect_obs("R9 reserved idle code", 4'h0, 2'b01, 20'h5AC00, 8'h50, 8'hA5, 8'h05, 8'h00);
        idle_pin_i = 4'b0010;

        mode_i = 1'b1;
        tick();
        expect_obs("R1 R4 enter register mode", 4'hA, 2'b10, 20'h0, 8'h00, 8'hA5, 8'h0A, 8'h00);

        wr(4'h2, 8'h1D);
        wr(4'h4, 8'hE4);
        wr(4'h1, 8'h0E);
        wr(4'h3, 8'hFF);
        wr(4'h0, 8'h12);
        rd_addr_i = 4'h2;
        expect_obs("R3 per lane registers", 4'hA, 2'b10, 20'h07412, 8'hE4, 8'hA5, 8'h0A, 8'h1D);
        rd_addr_i = 4'h3;
        expect_obs("R5 invalid eq clamped", 4'hA, 2'b10, 20'h07412, 8'hE4, 8'hA5, 8'h0A, 8'h00);

        strap_i = 4'b0101;
        expect_obs("R4 straps as address", 4'h5, 2'b10, 20'h07412, 8'hE4, 8'hA5, 8'h0A, 8'h00);

        wr(4'h5, 8'h03);
        rd_addr_i = 4'h5;
        expect_obs("R11 reserved rate write", 4'h5, 2'b10, 20'h07412, 8'hE4, 8'hA5, 8'h0A, 8'h02);
        wr(4'h5, 8'h00);
        expect_obs("R11 register rate over pin", 4'h5, 2'b00, 20'h07412, 8'hE4, 8'hA5, 8'h0A, 8'h00);

        wr(4'h8, 8'h01);
        rxdet_side_i = 2'b10;
        expect_obs("R6 pins live before write", 4'h5, 2'b00, 20'h07412, 8'hE4, 8'h5A, 8'h0A, 8'h00);
        wr(4'h6, 8'h99);
        rd_addr_i = 4'h6;
        expect_obs("R6 R12 termination taken", 4'h5, 2'b00, 20'h07412, 8'hE4, 8'h99, 8'h0A, 8'h99);
        rxdet_side_i = 2'b01; idle_pin_i = 4'b1000;
        expect_obs("R6 pins ignored idle live", 4'h5, 2'b00, 20'h07412, 8'hE4, 8'h99, 8'hA0, 8'h99);

        present_i = 1'b1;
        tick();
        present_i = 1'b0;
        tick();
        rd_addr_i = 4'h8;
        expect_obs("R8 presence retains", 4'h5, 2'b00, 20'h07412, 8'hE4, 8'h99, 8'hA0, 8'h01);

        strap_i = 4'b1010;
        mode_i = 1'b0;
        tick();
        rd_addr_i = 4'h6;
        expect_obs("R1 back to pin mode", 4'h0, 2'b01, 20'h5AC00, 8'h50, 8'hA5, 8'hA0, 8'hA5);
        mode_i = 1'b1;
        tick();
        rd_addr_i = 4'h8;
        expect_obs("R7 bank cleared on reentry", 4'hA, 2'b10, 20'h0, 8'h00, 8'hA5, 8'hA0, 8'h00);

        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule